// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

This block sits beside the inbound write path of a PCIe root-complex bridge. Every inbound memory write, presented on a simple valid/address/data strobe, is passed on one cycle later to the memory side unchanged. When capture is switched on and the 64-bit write address falls inside a programmed window (a 64-bit base and a byte size), the write's payload and full address are also pushed into a 16-entry queue. Software uses a zero-wait APB register port to program the window and to drain the queue.

Each queued message is taken apart by three separate 32-bit reads: the payload word, the low address half and the high address half. The head entry leaves the queue only once all three have been read. A pending flag stays set while any entry remains. A message summary bit in a shared interrupt status register, next to four legacy INTx level bits, drives a single interrupt output through an enable mask.

A message vector `v` from 0 to 15 targets `base + 4*v` and carries `v` as its payload, so a payload of zero is a valid message. The window must map onto real memory, because captured writes still go through to it.

Top module: `msg_capture_unit`

## Requirements
- R1: After reset every register reads 0, `fwd_wr_valid` is 0 and `irq_out` is 0.
- R2: A write is queued only when the enable register (offset 0x14, bit 0) is 1 and base <= address < base + size, using a full 64-bit compare. Addresses one below the base, at base + size, or with a different upper half are not queued.
- R3: The queue holds 16 entries and returns them in arrival order. A write that matches while 16 entries are queued is dropped and sets the sticky overflow bit, bit 1 of status (0x18). Writing 1 to that bit clears it.
- R4: Status bit 0 reads 1 exactly while at least one entry is queued.
- R5: The head entry is removed only after the payload word (0x20), the address-low word (0x24) and the address-high word (0x28) have each been read. Until then, repeated reads return the same head, and reading a subset leaves status bit 0 set.
- R6: While the queue is empty, reads of 0x20, 0x24 and 0x28 return 0 and count for nothing. The next entry still needs all three reads.
- R7: Every inbound write, queued or not, appears on the forward port exactly one cycle later with the same address and data.
- R8: Bit 3 of the shared status register (0x30) is set while the queue is non-empty. It is write-1-to-clear, reasserts while entries remain, and stays set after the queue drains until it is cleared.
- R9: A high level on `intx_lvl[i]` sets bit 5+i of the shared status register. These bits are sticky and write-1-to-clear.
- R10: `irq_out` is the registered OR of the shared status bits ANDed with the shared enable register (0x34). Only bits 3 and 8:5 of the enable register are writable.
- R11: A payload of 0 is queued and read back like any other value.
- R12: Register map: base low 0x04, base high 0x08, size 0x0c, enable 0x14, status 0x18, payload 0x20, address low 0x24, address high 0x28, shared status 0x30, shared enable 0x34. The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr_valid | input | 1 | Inbound memory write strobe |
| in_wr_addr | input | 64 | Inbound write byte address |
| in_wr_data | input | 32 | Inbound write payload |
| fwd_wr_valid | output | 1 | Forwarded write strobe |
| fwd_wr_addr | output | 64 | Forwarded write address |
| fwd_wr_data | output | 32 | Forwarded write payload |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| intx_lvl | input | INTX_N | Legacy INTx levels |
| irq_out | output | 1 | Shared interrupt output |

## Verification
The bench pushes addresses right at the window edges: one word below the base, the last byte inside, the first byte past the end, and addresses with a wrong upper half. A 32-bit-only compare would capture the wrong upper half, and an off-by-one limit would capture base + size. It reads only some of the three head words and checks that the pending flag holds. A design that popped on the payload read alone would lose addresses. It reads the empty queue before a message arrives, which a design that counted empty reads would pop early. It also fills the queue past sixteen entries, where a design without a full check would overwrite the oldest entry and break the order. Finally it clears the summary bit while entries remain and again after draining, which exposes a bit that is either not sticky or not reasserted.

// File: rtl/msgcap_pkg.sv
package msgcap_pkg;
  localparam int unsigned MSG_AW = 64;
  localparam int unsigned MSG_DW = 32;

  // register offsets (software decodes these)
  localparam logic [7:0] OFF_BASE_LO   = 8'h04;
  localparam logic [7:0] OFF_BASE_HI   = 8'h08;
  localparam logic [7:0] OFF_SIZE      = 8'h0c;
  localparam logic [7:0] OFF_ENABLE    = 8'h14;
  localparam logic [7:0] OFF_STATUS    = 8'h18;
  localparam logic [7:0] OFF_DATA      = 8'h20;
  localparam logic [7:0] OFF_ADDR_LO   = 8'h24;
  localparam logic [7:0] OFF_ADDR_HI   = 8'h28;
  localparam logic [7:0] OFF_MISC_STAT = 8'h30;
  localparam logic [7:0] OFF_MISC_EN   = 8'h34;

  // shared interrupt status layout
  localparam int unsigned MISC_W   = 32;
  localparam int unsigned MSI_BIT  = 3;
  localparam int unsigned INTX_LSB = 5;

  typedef struct packed {
    logic [MSG_AW-1:0] addr;
    logic [MSG_DW-1:0] data;
  } msg_entry_t;
endpackage

// File: rtl/msgcap_window.sv
module msgcap_window
  import msgcap_pkg::*;
#(
  parameter int unsigned AW = MSG_AW,
  parameter int unsigned DW = MSG_DW,
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          win_en,
  input  logic [AW-1:0] win_base,
  input  logic [SW-1:0] win_size,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  localparam int unsigned PADW = AW + 1 - SW;

  logic [AW:0] lim;
  logic        hit;

  // one bit wider so base + size cannot wrap
  assign lim = {1'b0, win_base} + {{PADW{1'b0}}, win_size};
  assign hit = win_en && (in_addr >= win_base) && ({1'b0, in_addr} < lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      fwd_valid <= in_valid;
      fwd_addr  <= in_addr;
      fwd_data  <= in_data;
      cap_valid <= in_valid && hit;
      cap_addr  <= in_addr;
      cap_data  <= in_data;
    end
  end

  // R7: every write reappears one cycle later unchanged
  p_fwd_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (fwd_valid && fwd_addr == $past(in_addr) && fwd_data == $past(in_data)));

  // R2: nothing is captured while capture is off
  p_no_capture_off_r2: assert property (@(posedge clk) disable iff (rst)
    !win_en |=> !cap_valid);
endmodule

// File: rtl/msgcap_fifo.sv
module msgcap_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         drop
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          full, push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && not_empty;
  assign drop      = push && full;
  assign head      = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: a push into a full queue leaves the occupancy alone
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));

  // R6: the register side never pops an empty queue
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/msgcap_regs.sv
module msgcap_regs
  import msgcap_pkg::*;
#(
  parameter int unsigned PADDR_W     = 12,
  parameter logic [31:0] MISC_EN_MSK = 32'h0000_01e8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  input  msg_entry_t         head,
  input  logic               q_not_empty,
  input  logic               q_drop,
  input  logic [MISC_W-1:0]  misc_status,
  output logic               win_en,
  output logic [MSG_AW-1:0]  win_base,
  output logic [31:0]        win_size,
  output logic               pop,
  output logic [MISC_W-1:0]  misc_clr,
  output logic [MISC_W-1:0]  misc_en
);
  logic [31:0] base_lo, base_hi;
  logic        ovf;
  logic [2:0]  seen, rd_sel;
  logic        wr_acc, rd_acc, setup;
  logic [31:0] rd_mux;

  function automatic logic at(input logic [PADDR_W-1:0] a, input logic [7:0] off);
    return a == PADDR_W'(off);
  endfunction

  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign setup    = psel && !penable;
  assign win_base = {base_hi, base_lo};

  // bit 0 payload, bit 1 address low, bit 2 address high
  assign rd_sel = {at(paddr, OFF_ADDR_HI), at(paddr, OFF_ADDR_LO), at(paddr, OFF_DATA)}
                  & {3{rd_acc && q_not_empty}};
  assign pop    = (rd_sel != 3'b000) && ((seen | rd_sel) == 3'b111);

  assign misc_clr = (wr_acc && at(paddr, OFF_MISC_STAT)) ? pwdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo  <= '0;
      base_hi  <= '0;
      win_size <= '0;
      win_en   <= 1'b0;
      misc_en  <= '0;
    end else if (wr_acc) begin
      if (at(paddr, OFF_BASE_LO)) base_lo  <= pwdata;
      if (at(paddr, OFF_BASE_HI)) base_hi  <= pwdata;
      if (at(paddr, OFF_SIZE))    win_size <= pwdata;
      if (at(paddr, OFF_ENABLE))  win_en   <= pwdata[0];
      if (at(paddr, OFF_MISC_EN)) misc_en  <= pwdata & MISC_EN_MSK;
    end
  end

  // sticky overflow: a new drop wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else     ovf <= q_drop || (ovf && !(wr_acc && at(paddr, OFF_STATUS) && pwdata[1]));
  end

  // read tracking restarts whenever a new head becomes current
  always_ff @(posedge clk) begin
    if (rst)      seen <= '0;
    else if (pop) seen <= '0;
    else          seen <= seen | rd_sel;
  end

  always_comb begin
    rd_mux = '0;
    if      (at(paddr, OFF_BASE_LO))   rd_mux = base_lo;
    else if (at(paddr, OFF_BASE_HI))   rd_mux = base_hi;
    else if (at(paddr, OFF_SIZE))      rd_mux = win_size;
    else if (at(paddr, OFF_ENABLE))    rd_mux = {31'b0, win_en};
    else if (at(paddr, OFF_STATUS))    rd_mux = {30'b0, ovf, q_not_empty};
    else if (at(paddr, OFF_DATA))      rd_mux = q_not_empty ? head.data : '0;
    else if (at(paddr, OFF_ADDR_LO))   rd_mux = q_not_empty ? head.addr[31:0] : '0;
    else if (at(paddr, OFF_ADDR_HI))   rd_mux = q_not_empty ? head.addr[63:32] : '0;
    else if (at(paddr, OFF_MISC_STAT)) rd_mux = misc_status;
    else if (at(paddr, OFF_MISC_EN))   rd_mux = misc_en;
  end

  // read data is registered in the setup phase, valid through the access phase
  always_ff @(posedge clk) begin
    if (rst)        prdata <= '0;
    else if (setup) prdata <= rd_mux;
  end
endmodule

// File: rtl/msgcap_irq.sv
module msgcap_irq
  import msgcap_pkg::*;
#(
  parameter int unsigned NB     = MISC_W,
  parameter int unsigned INTX_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_pending,
  input  logic [INTX_N-1:0] intx_lvl,
  input  logic [NB-1:0]     clr,
  input  logic [NB-1:0]     en,
  output logic [NB-1:0]     status,
  output logic              irq
);
  logic [NB-1:0] src;

  for (genvar b = 0; b < NB; b++) begin : g_src
    if (b == MSI_BIT) begin : g_msg
      assign src[b] = msg_pending;
    end else if (b >= INTX_LSB && b < INTX_LSB + INTX_N) begin : g_intx
      assign src[b] = intx_lvl[b - INTX_LSB];
    end else begin : g_none
      assign src[b] = 1'b0;
    end
  end

  // sticky, write-1-to-clear, a live source re-sets the bit
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | src;
      irq    <= |(status & en);
    end
  end

  // R8: a pending queue always shows in the summary bit
  p_msg_summary_r8: assert property (@(posedge clk) disable iff (rst)
    msg_pending |=> status[MSI_BIT]);

  // R10: the output follows enabled status one cycle later
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    (|(status & en)) |=> irq);
endmodule

// File: rtl/msg_capture_unit.sv
module msg_capture_unit
  import msgcap_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned PADDR_W = 12,
  parameter int unsigned INTX_N  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_wr_valid,
  input  logic [63:0]        in_wr_addr,
  input  logic [31:0]        in_wr_data,
  output logic               fwd_wr_valid,
  output logic [63:0]        fwd_wr_addr,
  output logic [31:0]        fwd_wr_data,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  input  logic [INTX_N-1:0]  intx_lvl,
  output logic               irq_out
);
  localparam logic [MISC_W-1:0] MISC_EN_MSK =
    (MISC_W'(1) << MSI_BIT) | (MISC_W'((1 << INTX_N) - 1) << INTX_LSB);

  logic              win_en, cap_valid, pop, q_not_empty, q_drop;
  logic [MSG_AW-1:0] win_base, cap_addr;
  logic [31:0]       win_size;
  logic [MSG_DW-1:0] cap_data;
  msg_entry_t        head, cap_entry;
  logic [MISC_W-1:0] misc_status, misc_clr, misc_en;

  assign cap_entry = '{addr: cap_addr, data: cap_data};

  msgcap_window #(.AW(MSG_AW), .DW(MSG_DW), .SW(32)) u_window (
    .clk, .rst,
    .in_valid (in_wr_valid), .in_addr (in_wr_addr), .in_data (in_wr_data),
    .win_en, .win_base, .win_size,
    .fwd_valid (fwd_wr_valid), .fwd_addr (fwd_wr_addr), .fwd_data (fwd_wr_data),
    .cap_valid, .cap_addr, .cap_data
  );

  msgcap_fifo #(.DEPTH(DEPTH), .W($bits(msg_entry_t))) u_fifo (
    .clk, .rst,
    .push (cap_valid), .push_data (cap_entry), .pop,
    .head, .not_empty (q_not_empty), .drop (q_drop)
  );

  msgcap_regs #(.PADDR_W(PADDR_W), .MISC_EN_MSK(MISC_EN_MSK)) u_regs (
    .clk, .rst, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .head, .q_not_empty, .q_drop, .misc_status,
    .win_en, .win_base, .win_size, .pop, .misc_clr, .misc_en
  );

  msgcap_irq #(.NB(MISC_W), .INTX_N(INTX_N)) u_irq (
    .clk, .rst, .msg_pending (q_not_empty), .intx_lvl,
    .clr (misc_clr), .en (misc_en), .status (misc_status), .irq (irq_out)
  );
endmodule

// File: tb/msg_capture_unit_bench.sv
`timescale 1ns/1ps
module msg_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_wr_valid = 1'b0;
  logic [63:0] in_wr_addr = '0;
  logic [31:0] in_wr_data = '0;
  logic        fwd_wr_valid;
  logic [63:0] fwd_wr_addr;
  logic [31:0] fwd_wr_data;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  intx_lvl = '0;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

  // {expect captured, address}
  localparam logic [64:0] WIN_VEC [8] = '{
    {1'b0, 64'h0000_0001_7fff_fffc},
    {1'b1, 64'h0000_0001_8000_0000},
    {1'b1, 64'h0000_0001_8000_0ffc},
    {1'b0, 64'h0000_0001_8000_1000},
    {1'b0, 64'h0000_0000_8000_0000},
    {1'b0, 64'h0000_0002_8000_0000},
    {1'b1, 64'h0000_0001_8000_0040},
    {1'b1, 64'h0000_0001_8000_0fff}
  };

  always #2.5 clk = ~clk;

  msg_capture_unit u_msg_capture_unit (
    .clk, .rst, .in_wr_valid, .in_wr_addr, .in_wr_data,
    .fwd_wr_valid, .fwd_wr_addr, .fwd_wr_data,
    .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .intx_lvl, .irq_out
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // inbound write; forward port checked one cycle later (R7)
  task automatic send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); in_wr_valid = 1; in_wr_addr = a; in_wr_data = d;
    @(negedge clk); in_wr_valid = 0;
    chk("R7 forward", {31'b0, fwd_wr_valid, fwd_wr_data}, {31'b0, 1'b1, d});
    chk("R7 forward addr", fwd_wr_addr, a);
    repeat (2) @(negedge clk);
  endtask

  task automatic take(output logic [31:0] d, output logic [63:0] a);
    logic [31:0] lo, hi;
    bus_rd(12'h020, d);
    bus_rd(12'h024, lo);
    bus_rd(12'h028, hi);
    a = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d;
    logic [63:0] a;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 fwd idle", {63'b0, fwd_wr_valid}, 0);
    chk("R1 irq", {63'b0, irq_out}, 0);
    bus_rd(12'h018, r); chk("R1 status", r, 0);
    bus_rd(12'h004, r); chk("R1 base lo", r, 0);
    bus_rd(12'h014, r); chk("R1 enable", r, 0);
    bus_rd(12'h030, r); chk("R1 misc status", r, 0);

    // R12 configuration and readback
    bus_wr(12'h004, BASE[31:0]);
    bus_wr(12'h008, BASE[63:32]);
    bus_wr(12'h00c, 32'h1000);
    bus_wr(12'h014, 32'h1);
    bus_rd(12'h008, r); chk("R12 base hi", r, 32'h1);
    bus_rd(12'h00c, r); chk("R12 size", r, 32'h1000);
    bus_rd(12'h014, r); chk("R12 enable", r, 32'h1);

    // R2 window table walk
    for (int i = 0; i < 8; i++) begin
      send(WIN_VEC[i][63:0], 32'hA500 + i);
      bus_rd(12'h018, r);
      chk("R2 window status", r, {31'b0, WIN_VEC[i][64]});
      if (WIN_VEC[i][64]) begin
        take(d, a);
        chk("R5 payload", d, 32'hA500 + i);
        chk("R5 address", a, WIN_VEC[i][63:0]);
        bus_rd(12'h018, r); chk("R4 empty after pop", r, 0);
      end
    end

    // R2 capture off
    bus_wr(12'h014, 32'h0);
    send(BASE, 32'h55);
    bus_rd(12'h018, r); chk("R2 disabled no capture", r, 0);
    bus_wr(12'h014, 32'h1);

    // R11 zero payload
    send(BASE, 32'h0);
    bus_rd(12'h018, r); chk("R11 zero queued", r, 1);
    take(d, a);
    chk("R11 zero payload", d, 0);
    chk("R11 zero address", a, BASE);

    // R5 partial reads keep the head
    send(BASE + 8, 32'h1234);
    bus_rd(12'h020, r);
    bus_rd(12'h018, r); chk("R5 data only keeps flag", r, 1);
    bus_rd(12'h020, r); chk("R5 same head", r, 32'h1234);
    bus_rd(12'h024, r); chk("R5 addr lo", r, BASE[31:0] + 8);
    bus_rd(12'h018, r); chk("R5 two reads keep flag", r, 1);
    bus_rd(12'h028, r); chk("R5 addr hi", r, 32'h1);
    bus_rd(12'h018, r); chk("R5 popped after third", r, 0);

    // R6 empty reads
    bus_rd(12'h020, r); chk("R6 empty data", r, 0);
    bus_rd(12'h024, r); chk("R6 empty lo", r, 0);
    bus_rd(12'h028, r); chk("R6 empty hi", r, 0);
    send(BASE + 12, 32'h77);
    bus_rd(12'h020, r); chk("R6 new head data", r, 32'h77);
    bus_rd(12'h024, r);
    bus_rd(12'h018, r); chk("R6 empty reads not counted", r, 1);
    bus_rd(12'h028, r);
    bus_rd(12'h018, r); chk("R6 popped", r, 0);

    // R3 overflow, R8 summary, R10 interrupt
    bus_wr(12'h030, 32'h8);
    for (int i = 0; i < 17; i++) send(BASE + 64'(4 * (i % 16)), i);
    bus_rd(12'h018, r); chk("R3 overflow set", r, 32'h3);
    bus_rd(12'h030, r); chk("R8 summary set", r, 32'h8);
    bus_wr(12'h030, 32'h8);
    bus_rd(12'h030, r); chk("R8 reasserts while queued", r, 32'h8);
    chk("R10 irq masked", {63'b0, irq_out}, 0);
    bus_wr(12'h034, 32'hffff_ffff);
    bus_rd(12'h034, r); chk("R10 enable mask", r, 32'h1e8);
    bus_wr(12'h034, 32'h8);
    repeat (3) @(negedge clk);
    chk("R10 irq on", {63'b0, irq_out}, 1);
    bus_wr(12'h018, 32'h2);
    bus_rd(12'h018, r); chk("R3 overflow cleared", r, 32'h1);
    for (int i = 0; i < 16; i++) begin
      take(d, a);
      chk("R3 order payload", d, i);
      chk("R3 order address", a, BASE + 64'(4 * i));
    end
    bus_rd(12'h018, r); chk("R4 drained", r, 0);
    bus_rd(12'h030, r); chk("R8 sticky after drain", r, 32'h8);
    bus_wr(12'h030, 32'h8);
    bus_rd(12'h030, r); chk("R8 cleared", r, 0);
    repeat (3) @(negedge clk);
    chk("R10 irq off", {63'b0, irq_out}, 0);

    // R9 legacy levels
    intx_lvl = 4'b0010;
    repeat (3) @(negedge clk);
    bus_rd(12'h030, r); chk("R9 intx bit 6", r, 32'h40);
    chk("R10 intx not enabled", {63'b0, irq_out}, 0);
    bus_wr(12'h034, 32'h48);
    repeat (3) @(negedge clk);
    chk("R10 intx irq", {63'b0, irq_out}, 1);
    intx_lvl = 4'b0000;
    bus_wr(12'h030, 32'h40);
    bus_rd(12'h030, r); chk("R9 intx cleared", r, 0);
    repeat (3) @(negedge clk);
    chk("R10 irq idle", {63'b0, irq_out}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule